// File: doc/BRIEF.md
# Phase-Accumulator PWM with Selectable Frequency

This block makes a pulse-width-modulated square wave whose rate is set by a phase accumulator, not by a divide-by-N counter. Each clock, a 10-bit pointer grows by a tuning word and wraps around modulo 1024, so the output rate can be a non-integer fraction of the clock. A 3-bit select input picks one of six preset rates. With a 50 MHz clock these are 5, 10, 15, 20, 25 and 30 MHz. The pointer, shifted left by six bits, forms a 16-bit sawtooth ramp. The ramp is compared against a threshold taken from an integer duty percentage, and the result drives a registered output and its inverse.

New select and duty values are taken only when the pointer wraps, so a change never cuts a period short. A small state machine tracks how the output is produced:

- **LOAD** is the single cycle after reset. It captures the first settings.
- **OFF** holds the output low.
- **RUN** uses the ramp comparison.
- **FULL** holds the output high.

There are four transitions:

- Reset enters LOAD.
- LOAD moves to the mode that the captured duty implies.
- OFF, RUN and FULL move to the mode of the freshly captured duty at each wrap.
- Without a wrap, each of those states stays where it is.

Top module: `accum_pwm`

## Requirements
- R1: An internal 10-bit pointer advances each clock by the currently held tuning word and wraps modulo 1024; a wrap is the cycle in which pointer plus tuning word reaches 1024 or more.
- R2: `freq_sel` values 0 to 5 select the tuning words 102, 204, 307, 409, 512 and 614, which equal floor(1024 × f_out / 50 MHz) for outputs of 5 to 30 MHz.
- R3: In RUN, `pwm_out` in the next cycle is 1 exactly when pointer × 64 is no greater than the threshold duty × 655 + floor(duty × 23 / 64), for held duty values 1 to 99; otherwise it is 0.
- R4: `pwm_out_n` is always the inverse of `pwm_out`, including during reset.
- R5: `freq_sel` and `duty_pct` are captured only in LOAD and in wrap cycles. The captured values take effect from the following clock, and changes at any other time have no effect until the next wrap.
- R6: A captured duty of 100 or more (`duty_pct` values 100 to 127) selects FULL, and `pwm_out` then stays 1 continuously.
- R7: A captured duty of 0 selects OFF, and `pwm_out` then stays 0 continuously.
- R8: Reset is synchronous and active low. While `rst_n` is 0 at a clock edge, the pointer, tuning word and duty are cleared, the state becomes LOAD, `pwm_out` is 0 and `pwm_out_n` is 1.
- R9: `freq_sel` values 6 and 7 select the lowest rate, tuning word 102, so they give the same output as value 0.
- R10: LOAD lasts exactly one cycle after reset is released, drives `pwm_out` low and moves to OFF, RUN or FULL according to the captured duty; those three states change state only at a wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| freq_sel | input | 3 | Output rate index; 0 to 5 are valid, larger values fall back to 0 |
| duty_pct | input | 7 | Duty cycle in integer percent; 0 is off, 100 and above is full on |
| pwm_out | output | 1 | Registered PWM output |
| pwm_out_n | output | 1 | Registered inverse of `pwm_out` |

## Verification
A 50 percent duty at the slowest rate exercises the basic ramp comparison and the wrap rhythm. Duty values of 0, 100 and above 100 separate the constant-level states from the comparator path. A select of 7 is replayed against a select of 0 from the same reset, which shows that out-of-range indices fall back to the lowest rate and not to some other word. Changing both inputs just after a rising edge distinguishes capture at the wrap from immediate capture. Seeded random runs mix every select and duty value, sometimes with a mid-stream reset, and are compared cycle by cycle with a reference model built from the requirements.

// File: rtl/accum_pwm_pkg.sv
package accum_pwm_pkg;

    // Output production mode of the PWM engine.
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_OFF  = 2'd1,
        ST_RUN  = 2'd2,
        ST_FULL = 2'd3
    } pwm_state_t;

    // Tuning word for preset index idx: floor(2^ptr_w * (idx+1)*step / clk).
    function automatic int unsigned tw_for(input int unsigned idx,
                                           input int unsigned clk_mhz,
                                           input int unsigned step_mhz,
                                           input int unsigned ptr_w);
        return ((32'd1 << ptr_w) * (idx + 1) * step_mhz) / clk_mhz;
    endfunction

endpackage

// File: rtl/accum_pwm_tw_rom.sv
module accum_pwm_tw_rom
    import accum_pwm_pkg::*;
#(
    parameter int SEL_W    = 3,
    parameter int PTR_W    = 10,
    parameter int N_FREQ   = 6,
    parameter int CLK_MHZ  = 50,
    parameter int STEP_MHZ = 5
) (
    input  logic [SEL_W-1:0] sel,
    output logic [PTR_W-1:0] tw
);

    logic [PTR_W-1:0] words [N_FREQ];

    for (genvar i = 0; i < N_FREQ; i++) begin : g_word
        localparam int unsigned WORD = tw_for(i, CLK_MHZ, STEP_MHZ, PTR_W);
        assign words[i] = WORD[PTR_W-1:0];
    end

    // Any index outside the preset list falls back to the slowest rate.
    always_comb begin
        tw = words[0];
        for (int i = 1; i < N_FREQ; i++) begin
            if (sel == SEL_W'(i)) begin
                tw = words[i];
            end
        end
    end

endmodule

// File: rtl/accum_pwm_phase_acc.sv
module accum_pwm_phase_acc #(
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] tw_in,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] tw_q,
    output logic             wrap
);

    logic [PTR_W:0] sum;

    assign sum  = {1'b0, ptr} + {1'b0, tw_q};
    assign wrap = sum[PTR_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            tw_q <= '0;
        end else begin
            ptr <= sum[PTR_W-1:0];
            if (load) begin
                tw_q <= tw_in;
            end
        end
    end

endmodule

// File: rtl/accum_pwm_thresh.sv
module accum_pwm_thresh #(
    parameter int DUTY_W    = 7,
    parameter int RAMP_W    = 16,
    parameter int DUTY_FULL = 100
) (
    input  logic [DUTY_W-1:0] duty,
    output logic [RAMP_W-1:0] thr
);

    // threshold = duty * 2^RAMP_W / DUTY_FULL, split into integer scale and a
    // fractional correction expressed in 1/64 steps.
    localparam int unsigned SCALE = (32'd1 << RAMP_W) / DUTY_FULL;
    localparam int unsigned REM   = (32'd1 << RAMP_W) % DUTY_FULL;
    localparam int unsigned CORR  = (REM * 64) / DUTY_FULL;

    logic [RAMP_W-1:0] base;
    logic [RAMP_W-1:0] frac;

    assign base = RAMP_W'(duty) * RAMP_W'(SCALE);
    assign frac = (RAMP_W'(duty) * RAMP_W'(CORR)) >> 6;

    always_comb begin
        if (duty >= DUTY_W'(DUTY_FULL)) begin
            thr = '1;
        end else begin
            thr = base + frac;
        end
    end

endmodule

// File: rtl/accum_pwm.sv
module accum_pwm
    import accum_pwm_pkg::*;
#(
    parameter int SEL_W     = 3,
    parameter int DUTY_W    = 7,
    parameter int PTR_W     = 10,
    parameter int RAMP_W    = 16,
    parameter int N_FREQ    = 6,
    parameter int CLK_MHZ   = 50,
    parameter int STEP_MHZ  = 5,
    parameter int DUTY_FULL = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  freq_sel,
    input  logic [DUTY_W-1:0] duty_pct,
    output logic              pwm_out,
    output logic              pwm_out_n
);

    localparam int RAMP_SHIFT = RAMP_W - PTR_W;

    pwm_state_t        state_q;
    pwm_state_t        state_d;
    pwm_state_t        mode_new;
    logic [DUTY_W-1:0] duty_q;
    logic [PTR_W-1:0]  ptr;
    logic [PTR_W-1:0]  tw_q;
    logic [PTR_W-1:0]  tw_sel;
    logic [RAMP_W-1:0] thr;
    logic [RAMP_W-1:0] ramp;
    logic              wrap;
    logic              capture;
    logic              pwm_q;
    logic              pwm_n_q;

    accum_pwm_tw_rom #(
        .SEL_W   (SEL_W),
        .PTR_W   (PTR_W),
        .N_FREQ  (N_FREQ),
        .CLK_MHZ (CLK_MHZ),
        .STEP_MHZ(STEP_MHZ)
    ) u_rom (
        .sel(freq_sel),
        .tw (tw_sel)
    );

    accum_pwm_phase_acc #(
        .PTR_W(PTR_W)
    ) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .load (capture),
        .tw_in(tw_sel),
        .ptr  (ptr),
        .tw_q (tw_q),
        .wrap (wrap)
    );

    accum_pwm_thresh #(
        .DUTY_W   (DUTY_W),
        .RAMP_W   (RAMP_W),
        .DUTY_FULL(DUTY_FULL)
    ) u_thr (
        .duty(duty_q),
        .thr (thr)
    );

    assign capture = (state_q == ST_LOAD) || wrap;
    assign ramp    = {ptr, {RAMP_SHIFT{1'b0}}};

    // Mode implied by the duty value being captured.
    always_comb begin
        if (duty_pct == '0) begin
            mode_new = ST_OFF;
        end else if (duty_pct >= DUTY_W'(DUTY_FULL)) begin
            mode_new = ST_FULL;
        end else begin
            mode_new = ST_RUN;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_LOAD: state_d = mode_new;
            ST_OFF,
            ST_RUN,
            ST_FULL: state_d = wrap ? mode_new : state_q;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // Duty setting, refreshed only at capture points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
        end else if (capture) begin
            duty_q <= duty_pct;
        end
    end

    // Output process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q   <= 1'b0;
            pwm_n_q <= 1'b1;
        end else begin
            unique case (state_q)
                ST_LOAD,
                ST_OFF: begin
                    pwm_q   <= 1'b0;
                    pwm_n_q <= 1'b1;
                end
                ST_FULL: begin
                    pwm_q   <= 1'b1;
                    pwm_n_q <= 1'b0;
                end
                ST_RUN: begin
                    pwm_q   <= (ramp <= thr);
                    pwm_n_q <= (ramp > thr);
                end
            endcase
        end
    end

    assign pwm_out   = pwm_q;
    assign pwm_out_n = pwm_n_q;

endmodule

// File: rtl/accum_pwm_chk.sv
module accum_pwm_chk
    import accum_pwm_pkg::*;
#(
    parameter int PTR_W     = 10,
    parameter int DUTY_W    = 7,
    parameter int DUTY_FULL = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm,
    input logic              pwm_n,
    input pwm_state_t        state,
    input logic [PTR_W-1:0]  tw_q,
    input logic [DUTY_W-1:0] duty_q,
    input logic              wrap
);

    a_r4_complement: assert property (@(posedge clk) disable iff (!rst_n)
        pwm != pwm_n);

    a_r8_reset_out: assert property (@(posedge clk)
        !rst_n |=> (!pwm && pwm_n));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LOAD && !wrap) |=> ($stable(tw_q) && $stable(duty_q)));

    a_r6_full_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) |=> pwm);

    a_r7_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> !pwm);

    a_r2_tw_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LOAD) |-> (tw_q != '0));

    a_r10_load_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (state != ST_LOAD));

    a_r10_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) |-> (duty_q >= DUTY_W'(DUTY_FULL)));

    a_r10_off_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (duty_q == '0));

endmodule

bind accum_pwm accum_pwm_chk #(
    .PTR_W    (PTR_W),
    .DUTY_W   (DUTY_W),
    .DUTY_FULL(DUTY_FULL)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .pwm   (pwm_out),
    .pwm_n (pwm_out_n),
    .state (state_q),
    .tw_q  (tw_q),
    .duty_q(duty_q),
    .wrap  (wrap)
);

// File: tb/tb_accum_pwm.sv
`timescale 1ns/1ps
module tb_accum_pwm;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] freq_sel = 3'd0;
    logic [6:0] duty_pct = 7'd0;
    logic       pwm_out;
    logic       pwm_out_n;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    // Reference model state: 0 LOAD, 1 OFF, 2 RUN, 3 FULL
    int  m_state = 0;
    int  m_ptr   = 0;
    int  m_tw    = 0;
    int  m_duty  = 0;
    bit  m_pwm   = 1'b0;

    bit  rec [300];

    always #2.5 clk = ~clk;

    accum_pwm dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .freq_sel (freq_sel),
        .duty_pct (duty_pct),
        .pwm_out  (pwm_out),
        .pwm_out_n(pwm_out_n)
    );

    function automatic int tw_of(input int s);
        case (s)
            1: return 204;
            2: return 307;
            3: return 409;
            4: return 512;
            5: return 614;
            default: return 102;
        endcase
    endfunction

    function automatic int thr_of(input int d);
        return d * 655 + (d * 23) / 64;
    endfunction

    function automatic int mode_of(input int d);
        if (d == 0) return 1;
        if (d >= 100) return 3;
        return 2;
    endfunction

    task automatic model_step();
        bit nxt;
        int sum;
        if (!rst_n) begin
            m_state = 0; m_ptr = 0; m_tw = 0; m_duty = 0; m_pwm = 1'b0;
        end else begin
            case (m_state)
                2:       nxt = (m_ptr * 64) <= thr_of(m_duty);
                3:       nxt = 1'b1;
                default: nxt = 1'b0;
            endcase
            sum = m_ptr + m_tw;
            if (m_state == 0 || sum >= 1024) begin
                m_tw    = tw_of(int'(freq_sel));
                m_duty  = int'(duty_pct);
                m_state = mode_of(int'(duty_pct));
            end
            m_ptr = sum % 1024;
            m_pwm = nxt;
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: advance model after the edge, compare at the falling edge.
    task automatic cyc(input string req);
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        check(pwm_out === m_pwm && pwm_out_n === !m_pwm, req,
              int'({pwm_out, pwm_out_n}), int'({m_pwm, !m_pwm}));
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) cyc(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        run(2, "R8 reset");
        rst_n = 1'b1;
    endtask

    initial begin
        int len;
        bit stuck;
        void'($urandom(32'd4242));

        // R8: outputs during reset
        run(3, "R8 reset");
        check(pwm_out === 1'b0, "R8 pwm_out in reset", int'(pwm_out), 0);
        check(pwm_out_n === 1'b1, "R4 R8 pwm_out_n in reset", int'(pwm_out_n), 1);

        // R10: first cycle after release is LOAD (low) even at full duty
        duty_pct = 7'd100; freq_sel = 3'd2;
        rst_n = 1'b1;
        cyc("R10 load cycle");
        check(pwm_out === 1'b0, "R10 LOAD drives low", int'(pwm_out), 0);
        cyc("R10 to FULL");
        check(pwm_out === 1'b1, "R10 FULL after LOAD", int'(pwm_out), 1);

        // R1 R3: basic ramp comparison at the slowest rate
        do_reset();
        freq_sel = 3'd0; duty_pct = 7'd50;
        run(600, "R1 R3 half duty");
        freq_sel = 3'd4; duty_pct = 7'd25;
        run(400, "R2 R3 quarter duty");

        // R7: zero duty stays low
        duty_pct = 7'd0; freq_sel = 3'd3;
        run(20, "R7 settle");
        stuck = 1'b1;
        for (int i = 0; i < 500; i++) begin
            cyc("R7 zero duty");
            if (pwm_out !== 1'b0) stuck = 1'b0;
        end
        check(stuck, "R7 output stays low", int'(stuck), 1);

        // R6: full and over-range duty stay high
        duty_pct = 7'd100; freq_sel = 3'd5;
        run(20, "R6 settle");
        stuck = 1'b1;
        for (int i = 0; i < 400; i++) begin
            cyc("R6 full duty");
            if (pwm_out !== 1'b1) stuck = 1'b0;
        end
        check(stuck, "R6 output stays high at 100", int'(stuck), 1);
        duty_pct = 7'd127;
        stuck = 1'b1;
        for (int i = 0; i < 400; i++) begin
            cyc("R6 over-range duty");
            if (pwm_out !== 1'b1) stuck = 1'b0;
        end
        check(stuck, "R6 output stays high at 127", int'(stuck), 1);

        // R5: change just after a rising edge is deferred to the wrap
        do_reset();
        freq_sel = 3'd0; duty_pct = 7'd50;
        run(30, "R5 lead-in");
        len = 0;
        while (len < 100) begin
            bit prev = pwm_out;
            cyc("R5 seek edge");
            len++;
            if (!prev && pwm_out) break;
        end
        duty_pct = 7'd0; freq_sel = 3'd5;
        cyc("R5 deferred");
        check(pwm_out === 1'b1, "R5 old duty still applied", int'(pwm_out), 1);
        run(40, "R5 new settings");
        check(pwm_out === 1'b0, "R5 new duty applied after wrap", int'(pwm_out), 0);

        // R9: select 7 and 6 reproduce select 0
        do_reset();
        freq_sel = 3'd0; duty_pct = 7'd40;
        for (int i = 0; i < 300; i++) begin
            cyc("R9 reference");
            rec[i] = pwm_out;
        end
        for (int s = 6; s < 8; s++) begin
            do_reset();
            freq_sel = 3'(s); duty_pct = 7'd40;
            stuck = 1'b1;
            for (int i = 0; i < 300; i++) begin
                cyc("R9 fallback");
                if (pwm_out !== rec[i]) stuck = 1'b0;
            end
            check(stuck, "R9 out-of-range select matches select 0", int'(stuck), 1);
        end

        // Seeded random mix
        for (int k = 0; k < 40; k++) begin
            if ($urandom % 10 == 0) do_reset();
            freq_sel = 3'($urandom % 8);
            duty_pct = 7'($urandom % 128);
            len = 20 + int'($urandom % 300);
            run(len, "R1 R2 R3 R5 R10 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule